// File: doc/BRIEF.md
# Condition code evaluator

This block keeps the four arithmetic status flags (negative, zero, carry, overflow) in a small register. It judges a 4-bit condition selector against them and raises a take-branch signal when the condition holds. A flag-write port with an enable loads all four flags on a rising clock edge. Without the enable the register keeps its value. An active-low asynchronous reset clears it.

The decision is purely combinational on the flags held in the register. In the cycle that writes new flags, the decision still reflects the old ones. Selector values come in complementary pairs: each odd code is the inverse of the even code below it. The two top codes both mean "always". Besides single-flag tests, the decoder resolves the unsigned relations (higher, lower-or-same) and the signed relations (greater-or-equal, less-than, greater-than, less-or-equal) from combinations of the flags.

Top module: `cond_eval`

## Requirements
- R1: While rst_ni is low, flags_o reads 4'b0000. Reset acts without waiting for a clock edge.
- R2: When flag_we_i is high at a rising edge of clk_i, flags_o equals flag_d_i after that edge. The bit order is {N,Z,C,V}: N is bit 3 and V is bit 0.
- R3: When flag_we_i is low at a rising edge, flags_o keeps its value, whatever flag_d_i carries.
- R4: Selector 4'b0000 takes when Z=1. Selector 4'b0001 takes when Z=0.
- R5: Selector 4'b0010 takes when C=1 and 4'b0011 when C=0. Selector 4'b0100 takes when N=1 and 4'b0101 when N=0. Selector 4'b0110 takes when V=1 and 4'b0111 when V=0.
- R6: Selector 4'b1000 (unsigned higher) takes when C=1 and Z=0. Selector 4'b1001 (lower or same) takes when C=0 or Z=1.
- R7: Selector 4'b1010 (signed greater or equal) takes when N equals V. Selector 4'b1011 (signed less than) takes when N differs from V.
- R8: Selector 4'b1100 (signed greater than) takes when Z=0 and N equals V. Selector 4'b1101 (less or equal) takes when Z=1 or N differs from V.
- R9: Selectors 4'b1110 and 4'b1111 always take, whatever the flags.
- R10: take_o depends only on cond_sel_i and the flags currently held. In a cycle where flag_we_i is high, take_o reflects the flags held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_we_i | input | 1 | Flag register write enable |
| flag_d_i | input | 4 | New flags {N,Z,C,V} |
| cond_sel_i | input | 4 | Condition selector |
| flags_o | output | 4 | Held flags {N,Z,C,V} |
| take_o | output | 1 | Condition satisfied |

## Verification
take_o is due in the same cycle as a selector change, with no register in its path. The bench therefore changes cond_sel_i on the falling edge and samples take_o one nanosecond later. flags_o is due one rising edge after a write, so each write is driven on a falling edge and checked after the next rising edge. The write-cycle case samples take_o before that edge, while the old flags are still held, and again after it. Reset is checked asynchronously, between clock edges.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int FLAG_W = 4;
  localparam int SEL_W  = 4;

  // bit positions inside the {N,Z,C,V} vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [SEL_W-1:0] {
    COND_EQ  = 4'b0000,
    COND_NE  = 4'b0001,
    COND_CS  = 4'b0010,
    COND_CC  = 4'b0011,
    COND_MI  = 4'b0100,
    COND_PL  = 4'b0101,
    COND_VS  = 4'b0110,
    COND_VC  = 4'b0111,
    COND_HI  = 4'b1000,
    COND_LS  = 4'b1001,
    COND_GE  = 4'b1010,
    COND_LT  = 4'b1011,
    COND_GT  = 4'b1100,
    COND_LE  = 4'b1101,
    COND_AL  = 4'b1110,
    COND_AL2 = 4'b1111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bit_q <= 1'b0;
      else if (we_i) bit_q <= d_i[g];
    end
    assign q_o[g] = bit_q;
  end
endmodule

// File: rtl/cc_cond_decode.sv
module cc_cond_decode
  import cc_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             take_o
);
  logic base;
  logic always_grp;
  logic sgn_ge;

  assign sgn_ge     = (flags_i.n == flags_i.v);
  assign always_grp = (sel_i[SEL_W-1:1] == '1);

  // even code of each pair; odd code inverts it
  always_comb begin
    unique case (sel_i[SEL_W-1:1])
      3'b000:  base = flags_i.z;
      3'b001:  base = flags_i.c;
      3'b010:  base = flags_i.n;
      3'b011:  base = flags_i.v;
      3'b100:  base = flags_i.c & ~flags_i.z;
      3'b101:  base = sgn_ge;
      3'b110:  base = sgn_ge & ~flags_i.z;
      default: base = 1'b1;
    endcase
  end

  assign take_o = base ^ (sel_i[0] & ~always_grp);
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flag_d_i,
  input  logic [SEL_W-1:0]  cond_sel_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              take_o
);
  logic [FLAG_W-1:0] flags_q;

  cc_flag_reg #(.W(FLAG_W)) u_flag_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (flag_we_i),
    .d_i   (flag_d_i),
    .q_o   (flags_q)
  );

  cc_cond_decode u_decode (
    .flags_i(flags_t'(flags_q)),
    .sel_i  (cond_sel_i),
    .take_o (take_o)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk
  import cc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flag_we_i,
  input logic [FLAG_W-1:0] flag_d_i,
  input logic [SEL_W-1:0]  cond_sel_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              take_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> flags_o == '0);

  // R2
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(flag_d_i));

  // R3
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  // R4
  eq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_i == COND_EQ |-> take_o == flags_o[FLAG_Z]);

  // R7
  ge_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_i == COND_GE |-> take_o == (flags_o[FLAG_N] == flags_o[FLAG_V]));

  // R9
  always_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_i[SEL_W-1:1] == 3'b111 |-> take_o);
endmodule

bind cond_eval cond_eval_chk u_chk (.*);

// File: tb/cond_eval_bench.sv
module cond_eval_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       flag_we_i = 1'b0;
  logic [3:0] flag_d_i = '0;
  logic [3:0] cond_sel_i = '0;
  logic [3:0] flags_o;
  logic       take_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cond_eval u_cond_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_we_i (flag_we_i),
    .flag_d_i  (flag_d_i),
    .cond_sel_i(cond_sel_i),
    .flags_o   (flags_o),
    .take_o    (take_o)
  );

  // {flags NZCV, selector, expected take}
  localparam int NV = 26;
  localparam logic [8:0] VEC [NV] = '{
    9'b0100_0000_1, 9'b0000_0000_0, 9'b0100_0001_0, 9'b0000_0001_1,
    9'b0010_0010_1, 9'b0010_0011_0, 9'b1000_0100_1, 9'b1000_0101_0,
    9'b0001_0110_1, 9'b0001_0111_0, 9'b0010_1000_1, 9'b0110_1000_0,
    9'b0110_1001_1, 9'b0000_1001_1, 9'b0010_1001_0, 9'b1001_1010_1,
    9'b1000_1010_0, 9'b1000_1011_1, 9'b0000_1100_1, 9'b0100_1100_0,
    9'b1001_1100_1, 9'b0001_1101_1, 9'b0100_1101_1, 9'b1001_1101_0,
    9'b0000_1110_1, 9'b1111_1111_1
  };

  function automatic string req_of(logic [3:0] s);
    if (s < 4'd2)       return "R4";
    else if (s < 4'd8)  return "R5";
    else if (s < 4'd10) return "R6";
    else if (s < 4'd12) return "R7";
    else if (s < 4'd14) return "R8";
    else                return "R9";
  endfunction

  // reference model, written per condition from the requirements
  function automatic logic model(logic [3:0] f, logic [3:0] s);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (s)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_flags(logic [3:0] f);
    @(negedge clk_i);
    flag_we_i = 1'b1;
    flag_d_i  = f;
    @(negedge clk_i);
    flag_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    #2;
    check("R1", flags_o, 4'b0000);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", flags_o, 4'b0000);
    rst_ni = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      load_flags(VEC[i][8:5]);
      check("R2", flags_o, VEC[i][8:5]);
      cond_sel_i = VEC[i][4:1];
      #1;
      check(req_of(VEC[i][4:1]), {3'b0, take_o}, {3'b0, VEC[i][0]});
    end

    // R3: write disabled, data toggling
    load_flags(4'b1010);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      flag_d_i = 4'(k * 5 + 1);
    end
    @(negedge clk_i);
    check("R3", flags_o, 4'b1010);
    cond_sel_i = 4'b1010;
    #1;
    check("R3", {3'b0, take_o}, 4'b0000);

    // R10: write cycle still sees old flags
    load_flags(4'b0100);
    cond_sel_i = 4'b0000;
    flag_we_i  = 1'b1;
    flag_d_i   = 4'b0000;
    #1;
    check("R10", {3'b0, take_o}, 4'b0001);
    @(posedge clk_i);
    #1;
    check("R10", {3'b0, take_o}, 4'b0000);
    flag_we_i = 1'b0;
    cond_sel_i = 4'b0001;
    #1;
    check("R10", {3'b0, take_o}, 4'b0001);

    // exhaustive sweep of flags x selectors
    for (int f = 0; f < 16; f++) begin
      load_flags(4'(f));
      for (int s = 0; s < 16; s++) begin
        @(negedge clk_i);
        cond_sel_i = 4'(s);
        #1;
        check(req_of(4'(s)), {3'b0, take_o}, {3'b0, model(4'(f), 4'(s))});
      end
    end

    // R1: asynchronous reset mid-run
    load_flags(4'b1111);
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    check("R1", flags_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cond_sel_i = 4'b0001;
    #1;
    check("R4", {3'b0, take_o}, 4'b0001);

    finish_run();
  end
endmodule